// File: doc/BRIEF.md
# Processor Supervisor Reset Controller

This block decides when a processor must be held in reset. It combines three causes: a supply-fault flag from an external voltage comparator, a mechanical pushbutton, and a watchdog that software must service by toggling a strobe line. Any of them drives the reset active. One shared stretch timer then keeps reset active for a minimum width after the cause goes away, so a short supply dip, a quick tap on the button and a watchdog expiry all give the processor the same settling time.

The raw pushbutton, strobe and supply-fault inputs are brought into the clock domain through two-flop synchronisers. The button is debounced with a stable-level counter. The watchdog period comes from one of three parameterised cycle counts, picked by a 2-bit select code. Two outputs are provided: an active-high reset, and a pull-low enable that stands in for an open-drain active-low reset pin. The synchronous power-on reset starts the block with reset active and the stretch timer loaded, so start-up gets the same minimum width.

Top module: `sup_reset_ctrl`

## Requirements
- R1: While `supply_bad_i` is 1, both outputs become active within 4 clock cycles and stay active for as long as it remains 1.
- R2: After `supply_bad_i` returns to 0, reset stays active for at least `STRETCH_CYC` cycles and is released within `STRETCH_CYC`+4 cycles.
- R3: After `rst_n` is released, reset stays active for at least `STRETCH_CYC`-1 cycles and no more than `STRETCH_CYC`+1 cycles.
- R4: The pushbutton is pressed when `pb_n_i` is 0. A press counts only after `pb_n_i` has been low for `DEB_CYC` consecutive synchronised cycles. A shorter low pulse has no effect on the outputs. A release must also be stable for `DEB_CYC` cycles.
- R5: A valid press gives a reset pulse of at least `STRETCH_CYC` cycles even if the button is released at once. A button held down keeps reset active while it is held, and for the stretch width after its debounced release.
- R6: If no strobe falling edge arrives within the selected watchdog period after reset is released, reset becomes active again. It then lasts at least `STRETCH_CYC` cycles.
- R7: A falling edge (1 to 0) on `strobe_i` restarts the watchdog period. A rising edge does not.
- R8: `dly_sel_i` picks the watchdog period: 0 gives `WD_SHORT`, 1 gives `WD_MED`, and 2 or 3 gives `WD_LONG` cycles.
- R9: The watchdog does not count while reset is active. A full period starts when reset is released, however long reset lasted.
- R10: `cpu_rst_o` and `pull_low_o` are always equal: 1 means reset active and the open-drain pin pulled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running timing clock |
| rst_n | input | 1 | Power-on reset, active low, sampled on the clock |
| supply_bad_i | input | 1 | Supply-fault flag from the comparator, 1 = out of tolerance (asynchronous) |
| pb_n_i | input | 1 | Raw pushbutton, 0 = pressed (asynchronous, bouncing) |
| strobe_i | input | 1 | Watchdog service strobe; a falling edge restarts the period |
| dly_sel_i | input | 2 | Watchdog period select: 0 short, 1 medium, 2/3 long |
| cpu_rst_o | output | 1 | Active-high processor reset |
| pull_low_o | output | 1 | Pull-down enable for the active-low open-drain reset |

## Verification
The hardest condition to reach is a watchdog expiry that starts from a known point. The counter is hidden, it is held clear while reset is active, and ordinary background strobing keeps it from ever expiring. Each watchdog scenario therefore stops strobing first, then forces a fresh reset with a brief supply fault. The low interval is measured from the cycle reset is released until it reasserts. This is done for every select code, after a fault held longer than the period, and with only a rising strobe edge inside the period.

// File: rtl/sup_pkg.sv
// Package: shared types for the processor supervisor.
// Assumes: nothing beyond IEEE 1800-2017.
package sup_pkg;

    // Watchdog period selection codes; the top code aliases the longest period.
    typedef enum logic [1:0] {
        DLY_SHORT    = 2'd0,
        DLY_MEDIUM   = 2'd1,
        DLY_LONG     = 2'd2,
        DLY_LONG_ALT = 2'd3
    } dly_sel_e;

endpackage

// File: rtl/sup_sync.sv
// Module: sup_sync
// Two-flop synchroniser for a vector of independent asynchronous bits.
// Assumes: each bit is a slow level, so bits need not stay coherent with each other.
module sup_sync #(
    parameter int unsigned W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Capture the raw inputs, then resample them once to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;

endmodule

// File: rtl/sup_debounce.sv
// Module: sup_debounce
// Debounces the synchronised active-low pushbutton. The debounced level changes
// only after the input has differed from it for DEB_CYC consecutive cycles.
// Assumes: pb_n_s is already synchronised to clk.
module sup_debounce #(
    parameter int unsigned DEB_CYC = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pb_n_s,
    output logic pressed_o
);

    localparam int unsigned CW = $clog2(DEB_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(DEB_CYC - 1);

    logic          level_q;   // debounced level, 1 = released
    logic [CW-1:0] cnt_q;

    // Count the cycles of disagreement; adopt the new level after DEB_CYC of them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= 1'b1;
            cnt_q   <= '0;
        end else if (pb_n_s == level_q) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            level_q <= pb_n_s;
            cnt_q   <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign pressed_o = ~level_q;

    // R4: a change of the debounced level always follows the sampled input.
    assert_level_follows_input_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (level_q != $past(level_q)) |-> (level_q == $past(pb_n_s)));

endmodule

// File: rtl/sup_watchdog.sv
// Module: sup_watchdog
// Counts cycles between strobe falling edges. Gives a one-cycle expiry pulse when
// the selected period passes without one. Held clear while reset is active.
// Assumes: strobe_s is synchronised; WD_SHORT <= WD_MED <= WD_LONG, all >= 2.
module sup_watchdog
    import sup_pkg::*;
#(
    parameter int unsigned WD_SHORT = 600,
    parameter int unsigned WD_MED   = 2400,
    parameter int unsigned WD_LONG  = 4800
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     strobe_s,
    input  dly_sel_e dly_sel,
    input  logic     rst_active,
    output logic     expire_o
);

    localparam int unsigned CW = $clog2(WD_LONG + 1);

    logic          st_prev_q;
    logic          st_fall;
    logic [CW-1:0] limit;
    logic [CW-1:0] cnt_q;
    logic          expire_q;

    // Remember the previous strobe level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) st_prev_q <= 1'b0;
        else        st_prev_q <= strobe_s;
    end

    assign st_fall = st_prev_q & ~strobe_s;

    // Map the select code to its period; the spare code takes the longest.
    always_comb begin
        unique case (dly_sel)
            DLY_SHORT:  limit = CW'(WD_SHORT);
            DLY_MEDIUM: limit = CW'(WD_MED);
            default:    limit = CW'(WD_LONG);
        endcase
    end

    // Period counter: cleared by reset or a strobe fall, pulses on reaching the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            expire_q <= 1'b0;
        end else if (rst_active || st_fall) begin
            cnt_q    <= '0;
            expire_q <= 1'b0;
        end else if (cnt_q >= limit - 1'b1) begin
            cnt_q    <= '0;
            expire_q <= 1'b1;
        end else begin
            cnt_q    <= cnt_q + 1'b1;
            expire_q <= 1'b0;
        end
    end

    assign expire_o = expire_q;

    // R7: a strobe fall is never followed directly by an expiry.
    assert_strobe_restarts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_fall |=> !expire_o);

    // R9: expiry only arises from a cycle in which reset was inactive.
    assert_no_expiry_in_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |-> !$past(rst_active));

endmodule

// File: rtl/sup_stretch.sv
// Module: sup_stretch
// Shared reset stretcher. Any hold or trigger cycle reloads the timer; reset stays
// active until the timer has run out STRETCH_CYC cycles after the last load.
// Assumes: STRETCH_CYC >= 2; the power-on reset loads the timer.
module sup_stretch #(
    parameter int unsigned STRETCH_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_i,
    input  logic trig_i,
    output logic rst_o
);

    localparam int unsigned CW = $clog2(STRETCH_CYC + 1);
    localparam logic [CW-1:0] FULL = CW'(STRETCH_CYC);

    logic          load;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_next;
    logic          rst_q;

    assign load = hold_i | trig_i;

    // Next timer value: reload on any cause, otherwise count down to zero.
    always_comb begin
        if (load)            cnt_next = FULL;
        else if (cnt_q != 0) cnt_next = cnt_q - 1'b1;
        else                 cnt_next = cnt_q;
    end

    // Timer and registered reset flag; power-on starts fully loaded and active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= FULL;
            rst_q <= 1'b1;
        end else begin
            cnt_q <= cnt_next;
            rst_q <= (cnt_next != 0);
        end
    end

    assign rst_o = rst_q;

    // Checker state: cycles since the last load or power-on, saturating.
    logic [CW-1:0] run_q;
    always_ff @(posedge clk) begin
        if (!rst_n || load)   run_q <= '0;
        else if (run_q != FULL) run_q <= run_q + 1'b1;
    end

    // R1: any active cause makes reset active on the next cycle.
    assert_cause_forces_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> rst_o);

    // R2: reset is never released before the minimum width has elapsed.
    assert_min_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_o) |-> (run_q >= FULL - 1'b1));

endmodule

// File: rtl/sup_reset_ctrl.sv
// Module: sup_reset_ctrl (top)
// Processor supervisor: merges the supply fault, the debounced pushbutton and the
// watchdog into one stretched reset, given active high and as a pull-low enable.
// Assumes: all inputs except clk/rst_n are asynchronous; rst_n is synchronous.
module sup_reset_ctrl
    import sup_pkg::*;
#(
    parameter int unsigned STRETCH_CYC = 1000,
    parameter int unsigned DEB_CYC     = 40,
    parameter int unsigned WD_SHORT    = 600,
    parameter int unsigned WD_MED      = 2400,
    parameter int unsigned WD_LONG     = 4800
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       supply_bad_i,
    input  logic       pb_n_i,
    input  logic       strobe_i,
    input  logic [1:0] dly_sel_i,
    output logic       cpu_rst_o,
    output logic       pull_low_o
);

    localparam int unsigned NSYNC = 3;
    localparam logic [NSYNC-1:0] SYNC_RST = 3'b010;  // button idles released

    logic [NSYNC-1:0] raw;
    logic [NSYNC-1:0] synced;
    logic             fault_s;
    logic             pb_n_s;
    logic             strobe_s;
    logic             pressed;
    logic             expire;
    logic             rst_active;

    assign raw = {strobe_i, pb_n_i, supply_bad_i};
    assign {strobe_s, pb_n_s, fault_s} = synced;

    sup_sync #(.W(NSYNC), .RST_VAL(SYNC_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw),
        .q_o   (synced)
    );

    sup_debounce #(.DEB_CYC(DEB_CYC)) u_debounce (
        .clk       (clk),
        .rst_n     (rst_n),
        .pb_n_s    (pb_n_s),
        .pressed_o (pressed)
    );

    sup_watchdog #(.WD_SHORT(WD_SHORT), .WD_MED(WD_MED), .WD_LONG(WD_LONG)) u_watchdog (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe_s   (strobe_s),
        .dly_sel    (dly_sel_e'(dly_sel_i)),
        .rst_active (rst_active),
        .expire_o   (expire)
    );

    sup_stretch #(.STRETCH_CYC(STRETCH_CYC)) u_stretch (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold_i (fault_s | pressed),
        .trig_i (expire),
        .rst_o  (rst_active)
    );

    assign cpu_rst_o  = rst_active;
    assign pull_low_o = rst_active;

    // R5: a debounced press is always accompanied by active reset one cycle later.
    assert_press_holds_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pressed |=> cpu_rst_o);

endmodule

// File: tb/tb_sup_reset_ctrl.sv
module tb_sup_reset_ctrl;

    localparam int S  = 40;
    localparam int D  = 6;
    localparam int WS = 80;
    localparam int WM = 160;
    localparam int WL = 320;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       supply_bad = 1'b0;
    logic       pb_n = 1'b1;
    logic       strobe_auto = 1'b0;
    logic       strobe_man = 1'b0;
    logic       auto_en = 1'b1;
    logic [1:0] dly_sel = 2'd2;
    logic       cpu_rst, pull_low;
    logic       strobe;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    assign strobe = auto_en ? strobe_auto : strobe_man;

    always #2 clk = ~clk;  // 250 MHz

    sup_reset_ctrl #(.STRETCH_CYC(S), .DEB_CYC(D), .WD_SHORT(WS), .WD_MED(WM), .WD_LONG(WL)) dut (
        .clk(clk), .rst_n(rst_n), .supply_bad_i(supply_bad), .pb_n_i(pb_n),
        .strobe_i(strobe), .dly_sel_i(dly_sel), .cpu_rst_o(cpu_rst), .pull_low_o(pull_low)
    );

    // Background service strobe: toggles every 10 cycles.
    initial begin
        forever begin
            repeat (10) @(negedge clk);
            strobe_auto = ~strobe_auto;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Count negedges with reset active, starting at the next one, until it drops.
    task automatic count_high(output int n);
        n = 0;
        @(negedge clk);
        while (cpu_rst && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    // Count negedges with reset inactive until it rises.
    task automatic count_low(output int n);
        n = 0;
        @(negedge clk);
        while (!cpu_rst && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    // Brief supply fault to start from a known released state.
    task automatic fresh_reset();
        int n;
        supply_bad = 1'b1;
        repeat (5) @(negedge clk);
        supply_bad = 1'b0;
        count_high(n);
    endtask

    task automatic t_power_on();
        int n;
        repeat (3) @(negedge clk);
        check(cpu_rst == 1 && pull_low == 1, "R10 reset state", cpu_rst, 1);
        rst_n = 1'b1;
        count_high(n);
        check(n >= S - 2 && n <= S + 1, "R3 power-on width", n, S);
        check(cpu_rst == pull_low, "R10 outputs agree", pull_low, cpu_rst);
    endtask

    task automatic t_fault();
        int n;
        bit bad = 0;
        supply_bad = 1'b1;
        repeat (4) @(negedge clk);
        check(cpu_rst == 1 && pull_low == 1, "R1 fault asserts", cpu_rst, 1);
        repeat (100) begin
            @(negedge clk);
            if (!cpu_rst || !pull_low) bad = 1;
        end
        check(!bad, "R1 held during fault", bad, 0);
        supply_bad = 1'b0;
        count_high(n);
        check(n >= S && n <= S + 4, "R2 release width", n, S + 2);
        check(cpu_rst == pull_low, "R10 outputs agree after release", pull_low, cpu_rst);
    endtask

    task automatic t_pb_glitch();
        bit seen = 0;
        pb_n = 1'b0;
        repeat (D - 2) @(negedge clk);
        pb_n = 1'b1;
        repeat (3 * D) begin
            @(negedge clk);
            if (cpu_rst) seen = 1;
        end
        check(!seen, "R4 short glitch ignored", seen, 0);
    endtask

    task automatic t_pb_tap();
        int n, w = 0;
        pb_n = 1'b0;
        repeat (D + 3) @(negedge clk);
        pb_n = 1'b1;
        while (!cpu_rst && w < 20) begin
            w++;
            @(negedge clk);
        end
        check(cpu_rst == 1, "R4 valid press asserts", cpu_rst, 1);
        count_high(n);
        check(n >= S && n <= S + 2 * D + 10, "R5 tap pulse width", n, S);
    endtask

    task automatic t_pb_hold();
        int n;
        bit bad = 0;
        pb_n = 1'b0;
        repeat (D + 5) @(negedge clk);
        repeat (3 * S) begin
            @(negedge clk);
            if (!cpu_rst) bad = 1;
        end
        check(!bad, "R5 held button keeps reset", bad, 0);
        pb_n = 1'b1;
        count_high(n);
        check(n >= S && n <= S + D + 6, "R5 width after release", n, S + D);
    endtask

    task automatic t_wd_period(input logic [1:0] sel, input int exp, input string req);
        int n, w;
        auto_en = 1'b0;
        strobe_man = 1'b0;
        dly_sel = sel;
        fresh_reset();
        count_low(n);
        check(n >= exp - 2 && n <= exp + 3, req, n, exp);
        count_high(w);
        check(w >= S - 1 && w <= S + 3, "R6 expiry reset width", w, S);
        auto_en = 1'b1;
    endtask

    task automatic t_wd_long_fault();
        int n;
        auto_en = 1'b0;
        strobe_man = 1'b0;
        dly_sel = 2'd0;
        supply_bad = 1'b1;
        repeat (2 * WS + 10) @(negedge clk);
        supply_bad = 1'b0;
        count_high(n);
        count_low(n);
        check(n >= WS - 2 && n <= WS + 3, "R9 fresh period after reset", n, WS);
        auto_en = 1'b1;
        fresh_reset();
    endtask

    task automatic t_wd_serviced();
        bit seen = 0;
        int n;
        auto_en = 1'b0;
        strobe_man = 1'b0;
        dly_sel = 2'd0;
        fresh_reset();
        repeat (8) begin
            repeat (WS / 4) @(negedge clk);
            strobe_man = 1'b1;
            repeat (WS / 4) @(negedge clk);
            strobe_man = 1'b0;
            if (cpu_rst) seen = 1;
        end
        check(!seen, "R7 falling strobes keep reset off", seen, 0);
        fresh_reset();
        repeat (WS / 2) @(negedge clk);
        strobe_man = 1'b1;  // rising edge only
        n = WS / 2;
        while (!cpu_rst && n < 5000) begin
            n++;
            @(negedge clk);
        end
        check(n >= WS - 2 && n <= WS + 4, "R7 rising edge does not restart", n, WS);
        strobe_man = 1'b0;
        auto_en = 1'b1;
        fresh_reset();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_power_on();
        t_fault();
        t_pb_glitch();
        t_pb_tap();
        t_pb_hold();
        t_wd_period(2'd0, WS, "R8 short period (R6)");
        t_wd_period(2'd1, WM, "R8 medium period");
        t_wd_period(2'd2, WL, "R8 long period");
        t_wd_period(2'd3, WL, "R8 spare code long");
        t_wd_long_fault();
        t_wd_serviced();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule